// File: doc/BRIEF.md
# Priority-Arbitrated Scanout and Raster Write Scheduler

This block sits in front of one true-dual-port frame memory and lets two clients share it without a second copy of the storage. One physical port is owned by the display scanout reader and is never blocked. The other port carries the rasterizer's pixel writes. A full 32-bit pixel is written in one access. A 4-bit packed pixel goes through a short read-modify-write sequence on the same port, and the raster write handshake is held off until that sequence finishes.

The memory is organised as 32-bit words. A raster write address is a nibble address: `{word, byte[1:0], nib}`. Bits 2:1 pick the byte inside the word, and bit 0 picks the half of that byte. For a 32-bit write the three low bits are ignored. The read-modify-write sequencer has four states. IDLE accepts any write. A 4-bit write accepted in IDLE moves the sequencer to RMW_READ, which issues the old-word read. RMW_WAIT captures the returned word with the nibble merged in. RMW_WRITE writes the merged word back and returns to IDLE. A 32-bit write accepted in IDLE writes at once and the sequencer stays in IDLE.

Top module: `dp_vram_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, `wr_ready` is 1 and `scan_valid` is 0.
- R2: `scan_valid` is high in exactly the cycles that follow a cycle with `scan_req` high. `scan_data` then holds the word at `scan_addr` as it was before any port-B write made at that same clock edge.
- R3: A 32-bit write (`wr_nib`=0) accepted while `wr_ready` is high updates the whole word in that cycle's clock edge, and `wr_ready` stays high in the next cycle.
- R4: After a 4-bit write (`wr_nib`=1) is accepted, `wr_ready` is low for exactly three cycles (RMW_READ, RMW_WAIT, RMW_WRITE) and then returns high.
- R5: A 4-bit write with address bit 0 = 0 replaces bits 3:0 of the byte chosen by address bits 2:1, and with bit 0 = 1 it replaces bits 7:4. The value comes from `wr_data[3:0]`. Every other bit of the word is unchanged.
- R6: A write presented while `wr_ready` is low has no effect on memory until it is accepted in a cycle with `wr_ready` high.
- R7: Two 4-bit writes back to back into the same byte both take effect. The second write merges into the result of the first.
- R8: Scanout latency and data stay correct whatever port B is doing, including during every read-modify-write state.
- R9: For a 32-bit write, address bits 2:0 do not affect which word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_req | input | 1 | Scanout read request |
| scan_addr | input | WORD_AW | Scanout word address |
| scan_valid | output | 1 | Scanout data valid, one cycle after the request |
| scan_data | output | 32 | Scanout read word |
| wr_valid | input | 1 | Raster write request |
| wr_ready | output | 1 | Raster write accepted when high together with wr_valid |
| wr_nib | input | 1 | 1 = 4-bit pixel write, 0 = 32-bit pixel write |
| wr_addr | input | WORD_AW+3 | Nibble address {word, byte, nib} |
| wr_data | input | 32 | Write data; only bits 3:0 are used for a 4-bit write |

## Verification
A scanout read and a port-B write can hit the same word in the same cycle. That write may be a direct 32-bit write or the write-back at the end of RMW_WRITE. The bench forces these collisions by restricting random addresses to sixteen words and issuing scanout reads on most cycles. It also holds a raster write pending through every stall. A behavioural model in the bench reads the golden byte array before it applies the writes of each edge. It compares `scan_data`, `scan_valid` and `wr_ready` on every cycle, so a design that returned new data, or that let a stalled write through early, shows a mismatch.

// File: rtl/vsch_pkg.sv
package vsch_pkg;
    localparam int WORD_W    = 32;
    localparam int NIB_W     = 4;
    localparam int NIBS      = WORD_W / NIB_W;
    localparam int NIB_SEL_W = $clog2(NIBS);

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_RMW_READ  = 2'd1,
        ST_RMW_WAIT  = 2'd2,
        ST_RMW_WRITE = 2'd3
    } rmw_state_t;
endpackage

// File: rtl/vsch_tdp_ram.sv
module vsch_tdp_ram #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_din,
    output logic [DW-1:0] a_dout,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_din,
    output logic [DW-1:0] b_dout
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Single backing array, two physical ports, read-old-data on each port.
    always_ff @(posedge clk) begin
        if (a_en) begin
            a_dout <= mem[a_addr];
            if (a_we) mem[a_addr] <= a_din;
        end
        if (b_en) begin
            b_dout <= mem[b_addr];
            if (b_we) mem[b_addr] <= b_din;
        end
    end
endmodule

// File: rtl/vsch_nib_merge.sv
module vsch_nib_merge
    import vsch_pkg::*;
(
    input  logic [WORD_W-1:0]    old_word,
    input  logic [NIB_SEL_W-1:0] sel,
    input  logic [NIB_W-1:0]     val,
    output logic [WORD_W-1:0]    merged
);
    for (genvar i = 0; i < NIBS; i++) begin : g_lane
        assign merged[i*NIB_W +: NIB_W] =
            (sel == NIB_SEL_W'(i)) ? val : old_word[i*NIB_W +: NIB_W];
    end
endmodule

// File: rtl/vsch_rmw_seq.sv
module vsch_rmw_seq
    import vsch_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_valid,
    input  logic                    wr_nib,
    input  logic [AW+NIB_SEL_W-1:0] wr_addr,
    input  logic [WORD_W-1:0]       wr_data,
    input  logic [WORD_W-1:0]       merged,
    output logic                    wr_ready,
    output logic                    b_en,
    output logic                    b_we,
    output logic [AW-1:0]           b_addr,
    output logic [WORD_W-1:0]       b_din,
    output logic [NIB_SEL_W-1:0]    pend_sel,
    output logic [NIB_W-1:0]        pend_val,
    output rmw_state_t              state
);
    rmw_state_t       state_nx;
    logic [AW-1:0]    pend_word;
    logic [WORD_W-1:0] merged_q;

    logic accept_nib;
    assign accept_nib = (state == ST_IDLE) && wr_valid && wr_nib;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (accept_nib) state_nx = ST_RMW_READ;
            ST_RMW_READ:  state_nx = ST_RMW_WAIT;
            ST_RMW_WAIT:  state_nx = ST_RMW_WRITE;
            ST_RMW_WRITE: state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // State register and captured operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pend_word <= '0;
            pend_sel  <= '0;
            pend_val  <= '0;
            merged_q  <= '0;
        end else begin
            state <= state_nx;
            if (accept_nib) begin
                pend_word <= wr_addr[AW+NIB_SEL_W-1:NIB_SEL_W];
                pend_sel  <= wr_addr[NIB_SEL_W-1:0];
                pend_val  <= wr_data[NIB_W-1:0];
            end
            if (state == ST_RMW_WAIT) merged_q <= merged;
        end
    end

    // Port-B and handshake outputs
    always_comb begin
        wr_ready = 1'b0;
        b_en     = 1'b0;
        b_we     = 1'b0;
        b_addr   = pend_word;
        b_din    = merged_q;
        unique case (state)
            ST_IDLE: begin
                wr_ready = 1'b1;
                if (wr_valid && !wr_nib) begin
                    b_en   = 1'b1;
                    b_we   = 1'b1;
                    b_addr = wr_addr[AW+NIB_SEL_W-1:NIB_SEL_W];
                    b_din  = wr_data;
                end
            end
            ST_RMW_READ:  b_en = 1'b1;
            ST_RMW_WAIT:  ;
            ST_RMW_WRITE: begin
                b_en = 1'b1;
                b_we = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dp_vram_sched.sv
module dp_vram_sched
    import vsch_pkg::*;
#(
    parameter int WORD_AW = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scan_req,
    input  logic [WORD_AW-1:0]         scan_addr,
    output logic                       scan_valid,
    output logic [WORD_W-1:0]          scan_data,
    input  logic                       wr_valid,
    output logic                       wr_ready,
    input  logic                       wr_nib,
    input  logic [WORD_AW+NIB_SEL_W-1:0] wr_addr,
    input  logic [WORD_W-1:0]          wr_data
);
    logic                 b_en;
    logic                 b_we;
    logic [WORD_AW-1:0]   b_addr;
    logic [WORD_W-1:0]    b_din;
    logic [WORD_W-1:0]    b_dout;
    logic [WORD_W-1:0]    merged;
    logic [NIB_SEL_W-1:0] pend_sel;
    logic [NIB_W-1:0]     pend_val;
    rmw_state_t           seq_state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scan_valid <= 1'b0;
        else        scan_valid <= scan_req;
    end

    vsch_tdp_ram #(.AW(WORD_AW), .DW(WORD_W)) u_ram (
        .clk    (clk),
        .a_en   (scan_req),
        .a_we   (1'b0),
        .a_addr (scan_addr),
        .a_din  ('0),
        .a_dout (scan_data),
        .b_en   (b_en),
        .b_we   (b_we),
        .b_addr (b_addr),
        .b_din  (b_din),
        .b_dout (b_dout)
    );

    vsch_rmw_seq #(.AW(WORD_AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_nib   (wr_nib),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .merged   (merged),
        .wr_ready (wr_ready),
        .b_en     (b_en),
        .b_we     (b_we),
        .b_addr   (b_addr),
        .b_din    (b_din),
        .pend_sel (pend_sel),
        .pend_val (pend_val),
        .state    (seq_state)
    );

    vsch_nib_merge u_merge (
        .old_word (b_dout),
        .sel      (pend_sel),
        .val      (pend_val),
        .merged   (merged)
    );
endmodule

// File: rtl/vsch_checker.sv
module vsch_checker
    import vsch_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scan_req,
    input logic       scan_valid,
    input logic       wr_valid,
    input logic       wr_ready,
    input logic       wr_nib,
    input logic       b_we,
    input rmw_state_t seq_state
);
    p_scan_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        scan_req |=> scan_valid);
    p_scan_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_req |=> !scan_valid);
    p_word_now_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && !wr_nib) |-> b_we);
    p_word_no_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && !wr_nib) |=> wr_ready);
    p_nib_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && wr_nib) |=> !wr_ready);
    p_stall_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ready && $past(!wr_ready) && $past(!wr_ready, 2)) |=> wr_ready);
    p_writeback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_RMW_WAIT) |=> b_we);
    p_stall_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ready && seq_state != ST_RMW_WRITE) |-> !b_we);
endmodule

bind dp_vram_sched vsch_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_req   (scan_req),
    .scan_valid (scan_valid),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_nib     (wr_nib),
    .b_we       (b_we),
    .seq_state  (seq_state)
);

// File: tb/dp_vram_sched_test.sv
module dp_vram_sched_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int WORDS = 1 << AW;
    localparam int MAX_CYCLES = 100000;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          scan_req = 0;
    logic [AW-1:0] scan_addr = '0;
    logic          scan_valid;
    logic [31:0]   scan_data;
    logic          wr_valid = 0;
    logic          wr_ready;
    logic          wr_nib = 0;
    logic [AW+2:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dp_vram_sched #(.WORD_AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .scan_req(scan_req), .scan_addr(scan_addr),
        .scan_valid(scan_valid), .scan_data(scan_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_nib(wr_nib), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    logic [7:0]  gold [WORDS*4];
    int          stall = 0;
    logic [AW+2:0] p_addr;
    logic [3:0]  p_val;
    logic        exp_ready = 1;
    logic        exp_sv = 0;
    logic [31:0] exp_sd = '0;
    string       cur_tag = "R2";

    function automatic logic [31:0] gword(int w);
        return {gold[4*w+3], gold[4*w+2], gold[4*w+1], gold[4*w]};
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: apply model at the edge, compare after the edge.
    task automatic tick();
        @(posedge clk);
        exp_sv = scan_req;
        if (scan_req) exp_sd = gword(int'(scan_addr));
        if (stall == 0) begin
            if (wr_valid && !wr_nib) begin
                for (int k = 0; k < 4; k++)
                    gold[4*int'(wr_addr[AW+2:3]) + k] = wr_data[8*k +: 8];
            end else if (wr_valid && wr_nib) begin
                p_addr = wr_addr;
                p_val  = wr_data[3:0];
                stall  = 3;
            end
        end else begin
            if (stall == 1) begin
                if (p_addr[0]) gold[int'(p_addr >> 1)][7:4] = p_val;
                else           gold[int'(p_addr >> 1)][3:0] = p_val;
            end
            stall--;
        end
        exp_ready = (stall == 0);
        @(negedge clk);
        check(wr_ready === exp_ready, "R4", {31'd0, wr_ready}, {31'd0, exp_ready});
        check(scan_valid === exp_sv, "R2", {31'd0, scan_valid}, {31'd0, exp_sv});
        if (exp_sv) check(scan_data === exp_sd, cur_tag, scan_data, exp_sd);
    endtask

    task automatic drive(bit sr, int sa, bit wv, bit wn, int wa, logic [31:0] wd);
        scan_req  = sr;
        scan_addr = AW'(sa);
        wr_valid  = wv;
        wr_nib    = wn;
        wr_addr   = (AW+3)'(wa);
        wr_data   = wd;
        tick();
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", MAX_CYCLES);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < WORDS*4; i++) gold[i] = 8'h00;
        repeat (3) @(negedge clk);
        check(wr_ready === 1'b1, "R1", {31'd0, wr_ready}, 32'd1);
        check(scan_valid === 1'b0, "R1", {31'd0, scan_valid}, 32'd0);
        rst_n = 1;
        @(negedge clk);
        check(wr_ready === 1'b1 && scan_valid === 1'b0, "R1",
              {30'd0, wr_ready, scan_valid}, 32'd2);

        // Clear the whole memory with 32-bit writes
        cur_tag = "R3";
        for (int w = 0; w < WORDS; w++) drive(0, 0, 1, 0, w << 3, 32'h0);

        // R9 / R3: low address bits ignored, single-cycle write
        drive(0, 0, 1, 0, (2 << 3) | 5, 32'h11223344);
        check(wr_ready === 1'b1, "R3", {31'd0, wr_ready}, 32'd1);
        drive(1, 2, 0, 0, 0, 0);
        check(scan_data === 32'h11223344, "R9", scan_data, 32'h11223344);

        // R5: high nibble of byte 1 of word 2, then R7: low nibble same byte
        cur_tag = "R5";
        drive(0, 0, 1, 1, 19, 32'hA);
        repeat (3) drive(0, 0, 0, 0, 0, 0);
        drive(1, 2, 1, 1, 18, 32'h5);
        check(scan_data === 32'h1122A344, "R5", scan_data, 32'h1122A344);
        repeat (3) drive(0, 0, 0, 0, 0, 0);
        drive(1, 2, 0, 0, 0, 0);
        check(scan_data === 32'h1122A544, "R7", scan_data, 32'h1122A544);

        // R6: 32-bit write held through a read-modify-write stall on word 4
        cur_tag = "R6";
        drive(0, 0, 1, 1, 4 << 3, 32'h7);
        drive(1, 4, 1, 0, 4 << 3, 32'hFFFFFFFF);
        drive(1, 4, 1, 0, 4 << 3, 32'hFFFFFFFF);
        drive(1, 4, 1, 0, 4 << 3, 32'hFFFFFFFF);
        check(scan_data === 32'h0, "R6", scan_data, 32'h0);
        drive(1, 4, 1, 0, 4 << 3, 32'hFFFFFFFF);
        check(scan_data === 32'h7, "R6", scan_data, 32'h7);
        drive(1, 4, 0, 0, 0, 0);
        check(scan_data === 32'hFFFFFFFF, "R6", scan_data, 32'hFFFFFFFF);

        // R8: random scanout against mixed writes, handshake honoured
        cur_tag = "R8";
        for (int c = 0; c < 4000; c++) begin
            bit          sr = ($urandom_range(0, 3) != 0);
            int          sa = $urandom_range(0, 15);
            bit          wv = wr_valid;
            bit          wn = wr_nib;
            int          wa = int'(wr_addr);
            logic [31:0] wd = wr_data;
            if (!(wr_valid && !exp_ready)) begin
                wv = ($urandom_range(0, 1) == 1);
                wn = ($urandom_range(0, 1) == 1);
                wa = ($urandom_range(0, 15) << 3) | $urandom_range(0, 7);
                wd = $urandom;
            end
            drive(sr, sa, wv, wn, wa, wd);
        end
        drive(0, 0, 0, 0, 0, 0);
        repeat (4) drive(0, 0, 0, 0, 0, 0);
        for (int w = 0; w < 16; w++) begin
            drive(1, w, 0, 0, 0, 0);
            check(scan_data === gword(w), "R8", scan_data, gword(w));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule